// File: doc/BRIEF.md
# Quad Two-Entry Byte FIFO Bank with Status and Flush Register

This block holds the four small byte queues that sit between one two-wire serial port engine and the processor. There is one queue each for the master receive path, the master transmit path, the slave receive path and the slave transmit path. Every queue stores at most two bytes. It is filled and drained by single-cycle push and pop strobes from the serial engine or from software. The queues are packed side by side on the data ports: queue 0 is master receive, queue 1 is master transmit, queue 2 is slave receive and queue 3 is slave transmit. Queue i uses byte lane i of `push_data` and `pop_data` and bit i of every strobe and flag vector.

A single 32-bit register shows a 2-bit state code for each queue and accepts flush requests. A 1 written to the master-transmit flush bit empties both the master transmit queue and the slave receive queue. A 1 written to the slave-transmit flush bit empties only the slave transmit queue. The flush bits clear themselves. Pushing to a full queue and popping from an empty one are both harmless. Each sets a sticky flag that only reset clears.

Top module: `quad_fifo_bank`

## Requirements
- R1: After reset every queue is empty, `reg_rdata` reads 0, `pop_data` is 0, and all overflow and underflow flags are 0.
- R2: `reg_rdata` holds a 2-bit code per queue. Queue 0 is at bits 7:6, queue 1 at 5:4, queue 2 at 3:2 and queue 3 at 1:0. The codes are 00 = empty, 10 = one byte held and 11 = two bytes held. Bits 31:10 always read 0.
- R3: A push into an empty queue shows code 01 for exactly one cycle after the push edge. The code then becomes 10, or 11 if a second push arrived in that cycle.
- R4: Bytes leave a queue in the order they entered. A pop loads the head byte into that queue's lane of `pop_data` at the pop edge, and the lane holds that value until the next successful pop.
- R5: A push to a queue that holds two bytes is dropped and sets that queue's sticky `ovf` bit. This holds even when a pop arrives in the same cycle.
- R6: A pop from an empty queue leaves that queue's lane of `pop_data` unchanged and sets that queue's sticky `unf` bit.
- R7: A push and a pop in the same cycle on a queue holding one byte keep its occupancy at one. The popped byte is the old one, and the new byte comes out next.
- R8: Writing 1 to `reg_wdata` bit 9 empties queue 1 (master transmit) and queue 2 (slave receive) at the next clock edge. Queues 0 and 3 are left unchanged.
- R9: Writing 1 to `reg_wdata` bit 8 empties queue 3 (slave transmit) at the next clock edge. Queues 0, 1 and 2 are left unchanged.
- R10: A flush bit written as 1 reads back as 1 in `reg_rdata` (bit 9 or bit 8) for the one cycle before the flush edge. It reads 0 afterwards unless it is written again.
- R11: A flush wins over a push or a pop to the same queue in the flush cycle. The queue ends empty with code 00, no byte is stored or popped, and neither sticky flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 4 | Push strobe per queue |
| push_data | input | 32 | Byte to push, lane i for queue i |
| pop | input | 4 | Pop strobe per queue |
| pop_data | output | 32 | Last popped byte, lane i for queue i |
| ovf | output | 4 | Sticky overflow flag per queue |
| unf | output | 4 | Sticky underflow flag per queue |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (bits 9 and 8 are flush requests) |
| reg_rdata | output | 32 | Status and flush register read value |

## Verification
A flush reaches its queues in the cycle after the register write. In that cycle the serial side may still be pushing or popping, so these two functions can meet in a single clock. The bench provokes the clash directly by writing a flush and driving push and pop on the affected queues in the following cycle. The random phase does the same with rare register writes over constant queue traffic. A bench model that gives the flush priority judges the outcome: the state code must be 00, the popped byte lane must be unchanged and the sticky flags must not move.

// File: rtl/qfb_pkg.sv
package qfb_pkg;

    localparam int NUM_Q   = 4;
    localparam int REG_W   = 32;

    localparam int Q_MRX   = 0;
    localparam int Q_MTX   = 1;
    localparam int Q_SRX   = 2;
    localparam int Q_STX   = 3;

    localparam int FLB_MTX = 9;
    localparam int FLB_STX = 8;
    localparam int STAT_TOP = 7;

    typedef enum logic [1:0] {
        QS_EMPTY = 2'b00,
        QS_FRESH = 2'b01,
        QS_ONE   = 2'b10,
        QS_FULL  = 2'b11
    } qstat_e;

endpackage

// File: rtl/qfb_queue.sv
module qfb_queue
    import qfb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output qstat_e        status,
    output logic          ovf,
    output logic          unf
);

    localparam int DEPTH = 2;
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
        logic                     fresh;
        logic [DW-1:0]            dout;
        logic                     ovf;
        logic                     unf;
    } qstate_t;

    qstate_t st_d, st_q;
    logic    push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt != CNT_FULL);
        pop_ok  = pop  && (st_q.cnt != '0);
        if (flush) begin
            st_d.cnt   = '0;
            st_d.wr    = '0;
            st_d.rd    = '0;
            st_d.fresh = 1'b0;
        end else begin
            st_d.fresh = push_ok && (st_q.cnt == '0);
            if (push && !push_ok) st_d.ovf = 1'b1;
            if (pop && !pop_ok)   st_d.unf = 1'b1;
            if (pop_ok) begin
                st_d.dout = st_q.mem[st_q.rd];
                st_d.rd   = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + 1'b1;
            end
            if (push_ok) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.cnt == '0)          status = QS_EMPTY;
        else if (st_q.cnt == CNT_FULL) status = QS_FULL;
        else if (st_q.fresh)         status = QS_FRESH;
        else                         status = QS_ONE;
    end

    assign pop_data = st_q.dout;
    assign ovf      = st_q.ovf;
    assign unf      = st_q.unf;

    a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL);

    a_r3_fresh_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (status == QS_FRESH) |=> (status != QS_FRESH));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (status == QS_FULL && push && !pop && !flush) |=> (status == QS_FULL && ovf));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status == QS_EMPTY && pop && !flush) |=> ($stable(pop_data) && unf));

    a_r6_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

    a_r7_push_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == QS_ONE || status == QS_FRESH) && push && pop && !flush)
            |=> (status == QS_ONE));

    a_r11_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status == QS_EMPTY && $stable(pop_data)
                   && $stable(ovf) && $stable(unf)));

endmodule

// File: rtl/qfb_regs.sv
module qfb_regs
    import qfb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [2*NUM_Q-1:0] status_flat,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [NUM_Q-1:0]   flush_vec
);

    typedef struct packed {
        logic fl_mtx;
        logic fl_stx;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = '0;
        if (reg_we) begin
            rg_d.fl_mtx = reg_wdata[FLB_MTX];
            rg_d.fl_stx = reg_wdata[FLB_STX];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        flush_vec        = '0;
        flush_vec[Q_MTX] = rg_q.fl_mtx;
        flush_vec[Q_SRX] = rg_q.fl_mtx;
        flush_vec[Q_STX] = rg_q.fl_stx;
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[FLB_MTX] = rg_q.fl_mtx;
        reg_rdata[FLB_STX] = rg_q.fl_stx;
        for (int i = 0; i < NUM_Q; i++) begin
            reg_rdata[STAT_TOP - 2*i -: 2] = status_flat[2*i +: 2];
        end
    end

    a_r10_flush_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> (reg_rdata[FLB_MTX] == 1'b0 && reg_rdata[FLB_STX] == 1'b0));

    a_r8_pair_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[FLB_MTX]) |=> (flush_vec[Q_MTX] && flush_vec[Q_SRX]));

    a_r9_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[FLB_STX] && !reg_wdata[FLB_MTX])
            |=> (flush_vec[Q_STX] && !flush_vec[Q_MTX] && !flush_vec[Q_MRX]));

endmodule

// File: rtl/quad_fifo_bank.sv
module quad_fifo_bank
    import qfb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_Q-1:0]    push,
    input  logic [NUM_Q*DW-1:0] push_data,
    input  logic [NUM_Q-1:0]    pop,
    output logic [NUM_Q*DW-1:0] pop_data,
    output logic [NUM_Q-1:0]    ovf,
    output logic [NUM_Q-1:0]    unf,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata
);

    logic [NUM_Q-1:0]   flush_vec;
    logic [2*NUM_Q-1:0] status_flat;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        qstat_e st;
        qfb_queue #(.DW(DW)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush_vec[g]),
            .push      (push[g]),
            .push_data (push_data[g*DW +: DW]),
            .pop       (pop[g]),
            .pop_data  (pop_data[g*DW +: DW]),
            .status    (st),
            .ovf       (ovf[g]),
            .unf       (unf[g])
        );
        assign status_flat[2*g +: 2] = st;
    end

    qfb_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .status_flat (status_flat),
        .reg_rdata   (reg_rdata),
        .flush_vec   (flush_vec)
    );

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:10] == '0);

    a_r12_mrx_not_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7:6] == 2'b11 && !pop[Q_MRX]) |=> (reg_rdata[7:6] == 2'b11));

endmodule

// File: tb/quad_fifo_bank_bench.sv
module quad_fifo_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  push = '0, pop = '0;
    logic [31:0] push_data = '0;
    logic [31:0] pop_data;
    logic [3:0]  ovf, unf;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    string tag = "R1";

    logic [7:0] mq [4][2];
    int         mc [4];
    bit         mfr [4];
    logic [7:0] md [4];
    bit         mo [4];
    bit         mu [4];
    logic [1:0] mfl;

    always #10 clk = ~clk;

    quad_fifo_bank u_quad_fifo_bank (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .ovf(ovf), .unf(unf),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [1:0] code_of(int i);
        if (mc[i] == 0) return 2'b00;
        if (mc[i] == 2) return 2'b11;
        return mfr[i] ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = '0;
        r[9:8] = mfl;
        for (int i = 0; i < 4; i++) r[7-2*i -: 2] = code_of(i);
        return r;
    endfunction

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            mc[i] = 0; mfr[i] = 0; md[i] = '0; mo[i] = 0; mu[i] = 0;
            mq[i][0] = '0; mq[i][1] = '0;
        end
        mfl = 2'b00;
    endtask

    task automatic model_next();
        logic [3:0] fv;
        fv = {mfl[0], mfl[1], mfl[1], 1'b0};
        for (int i = 0; i < 4; i++) begin
            int  oc;
            bit  pu_ok, po_ok;
            oc = mc[i];
            if (fv[i]) begin
                mc[i] = 0; mfr[i] = 0;
            end else begin
                pu_ok = push[i] && oc < 2;
                po_ok = pop[i] && oc > 0;
                if (push[i] && !pu_ok) mo[i] = 1;
                if (pop[i] && !po_ok)  mu[i] = 1;
                if (po_ok) begin
                    md[i] = mq[i][0];
                    mq[i][0] = mq[i][1];
                    mc[i] = mc[i] - 1;
                end
                if (pu_ok) begin
                    mq[i][mc[i]] = push_data[8*i +: 8];
                    mc[i] = mc[i] + 1;
                end
                mfr[i] = pu_ok && oc == 0;
            end
        end
        mfl = reg_we ? reg_wdata[9:8] : 2'b00;
    endtask

    task automatic check_all();
        chk({tag, " status"}, reg_rdata, exp_rdata());
        chk({tag, " pop_data"}, pop_data, {md[3], md[2], md[1], md[0]});
        chk({tag, " ovf"}, {28'd0, ovf}, {28'd0, mo[3], mo[2], mo[1], mo[0]});
        chk({tag, " unf"}, {28'd0, unf}, {28'd0, mu[3], mu[2], mu[1], mu[0]});
    endtask

    task automatic step(logic [3:0] pu, logic [31:0] pd, logic [3:0] po,
                        logic we, logic [31:0] wd);
        @(negedge clk);
        check_all();
        push = pu; push_data = pd; pop = po; reg_we = we; reg_wdata = wd;
        model_next();
    endtask

    task automatic idle();
        step('0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tag = "R1";
        idle();
        chk("R1 rdata literal", reg_rdata, 32'h0);

        // R3: fresh code after push into empty queue 0
        tag = "R3";
        step(4'b0001, 32'h0000_00A1, '0, 0, '0);
        idle();
        chk("R3 code 01", {30'd0, reg_rdata[7:6]}, 32'd1);
        idle();
        chk("R3 settles 10", {30'd0, reg_rdata[7:6]}, 32'd2);

        // R4: order on queue 1
        tag = "R4";
        step(4'b0010, 32'h0000_1100, '0, 0, '0);
        step(4'b0010, 32'h0000_2200, '0, 0, '0);
        idle();
        chk("R2 full code 11", {30'd0, reg_rdata[5:4]}, 32'd3);
        step('0, '0, 4'b0010, 0, '0);
        idle();
        chk("R4 first out", {24'd0, pop_data[15:8]}, 32'h11);
        step('0, '0, 4'b0010, 0, '0);
        idle();
        chk("R4 second out", {24'd0, pop_data[15:8]}, 32'h22);

        // R5: overflow on queue 2, also with same-cycle pop
        tag = "R5";
        step(4'b0100, 32'h0031_0000, '0, 0, '0);
        step(4'b0100, 32'h0032_0000, '0, 0, '0);
        step(4'b0100, 32'h0033_0000, 4'b0100, 0, '0);
        idle();
        chk("R5 ovf set", {31'd0, ovf[2]}, 32'd1);

        // R6: underflow on queue 3
        tag = "R6";
        step('0, '0, 4'b1000, 0, '0);
        idle();
        chk("R6 unf set", {31'd0, unf[3]}, 32'd1);

        // R7: push+pop on one-byte queue 0
        tag = "R7";
        step(4'b0001, 32'h0000_00B2, 4'b0001, 0, '0);
        idle();
        chk("R7 stays one", {30'd0, reg_rdata[7:6]}, 32'd2);
        step('0, '0, 4'b0001, 0, '0);
        idle();
        chk("R7 new byte", {24'd0, pop_data[7:0]}, 32'hB2);

        // R8 / R10: bit 9 flush
        tag = "R8";
        step(4'b1111, 32'h4444_4444, '0, 0, '0);
        step('0, '0, '0, 1, 32'h0000_0200);
        idle();
        chk("R10 bit9 reads 1", {31'd0, reg_rdata[9]}, 32'd1);
        idle();
        chk("R10 bit9 cleared", {31'd0, reg_rdata[9]}, 32'd0);

        // R9: bit 8 flush
        tag = "R9";
        step(4'b1000, 32'h5500_0000, '0, 1, 32'h0000_0100);
        idle();
        idle();
        chk("R9 stx empty", {30'd0, reg_rdata[1:0]}, 32'd0);

        // R11: flush clashes with push/pop
        tag = "R11";
        step(4'b0110, 32'h0066_7700, '0, 1, 32'h0000_0300);
        step(4'b1110, 32'h8888_8800, 4'b1110, 0, '0);
        idle();
        chk("R11 mtx empty", {30'd0, reg_rdata[5:4]}, 32'd0);
        chk("R11 stx empty", {30'd0, reg_rdata[1:0]}, 32'd0);

        // Random mix, all requirements checked by the model
        tag = "R2/R4/R5/R6/R7/R8/R9/R11";
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wd;
            logic        we;
            we = ($urandom % 12) == 0;
            wd = $urandom;
            step(4'($urandom), $urandom, 4'($urandom), we, wd);
        end
        idle();
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule